// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Engine

This block moves outgoing frame data from host memory into a local transmit FIFO. The host builds a chain of descriptors in memory. Each descriptor starts with a link to the next one, then a frame-control word, then one or more fragment entries. Each entry is an address word followed by a length word. Writing the address of the first descriptor into the list-pointer input starts the engine. The engine then walks the chain one word read at a time. It loads each fragment's address and length into its own transfer registers and copies the fragment into the FIFO as 32-bit words.

Before each fragment the engine checks the FIFO free-space count. A fragment may start only when at least 16 bytes are free. In addition, either the whole fragment must fit in the free space, or the free space must reach 32 bytes times the programmed burst threshold. A halt input holds the engine before any fragment starts. The engine also owns the transmit-enable state that gates the MAC. It is off after reset. When it is turned off while a frame is on the wire, the drop waits until that frame ends.

Top module: `txdma_chain`

## Requirements
- R1: A write to the list pointer with a non-zero value while the engine is idle starts a walk at that byte address. A write of zero, or any write while a walk is running, is ignored.
- R2: Descriptor word layout, at byte offsets from the descriptor base: +0 is the next pointer, +4 is the control word (read and discarded), and from +8 come pairs of fragment address and fragment length. In each length word, bit 31 set marks the last fragment of the descriptor and bits 15:0 hold the byte count. Fragment addresses are word aligned. The FIFO receives the bytes of every fragment in list order.
- R3: A fragment starts moving only when fifo_free is at least 16, and also either its byte count is at most fifo_free or fifo_free is at least 32 times burst_thresh. Until then no data read is issued.
- R4: While halt is high, no fragment transfer begins. A fragment already moving finishes.
- R5: A fragment whose byte count is zero moves no data and costs only its two descriptor reads.
- R6: Each FIFO write carries one memory word, little-endian (byte 0 in bits 7:0). fifo_wbytes gives the number of valid low bytes, from 1 to 4. The total bytes written for a fragment equal its byte count exactly.
- R7: After the descriptor whose next pointer is zero, the engine returns to idle and pulses list_done high for exactly one cycle. A non-zero next pointer is followed.
- R8: overrun goes high on the cycle after a FIFO write made while fifo_full is high. It stays high until reset.
- R9: mac_tx_en is low after reset. A tx_enable_set pulse raises it at the next clock edge. The engine moves data into the FIFO whether or not transmission is enabled.
- R10: A tx_disable_set pulse lowers mac_tx_en at the first clock edge at which mac_frame_active is low. If a frame is active, the drop is deferred until that frame ends. An enable pulse cancels a pending disable.
- R11: Memory reads are one-cycle mem_req pulses with at most one read outstanding. The read count of a list is 2 per descriptor, plus 2 per fragment, plus one per data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| list_ptr_wr | input | 1 | List-pointer write strobe |
| list_ptr_data | input | 32 | First descriptor byte address |
| burst_thresh | input | THR_W | Burst threshold, in units of 32 bytes |
| halt | input | 1 | Holds off new fragment transfers |
| tx_enable_set | input | 1 | Pulse that turns transmission on |
| tx_disable_set | input | 1 | Pulse that requests transmission off |
| mac_frame_active | input | 1 | MAC is sending a frame |
| mac_tx_en | output | 1 | Transmit enable toward the MAC |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| fifo_free | input | FREE_W | FIFO free space in bytes |
| fifo_full | input | 1 | FIFO has no room |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| fifo_wbytes | output | 3 | Valid low bytes in fifo_wdata (1 to 4) |
| overrun | output | 1 | Sticky FIFO overrun flag |
| list_done | output | 1 | One-cycle pulse at the end of a list |

## Verification
mac_tx_en is due one clock edge after an enable pulse, or after the edge at which mac_frame_active falls while a disable is pending. The bench samples it on the falling edge right after that rising edge. The memory model answers each read two cycles later, so the timing of a list's data is not fixed. Data-path results are therefore checked once list_done has pulsed: the captured byte stream, the byte count, the read count and the number of done pulses. For hold-off cases (halt, start rule, ignored pointer writes), the bench waits a window of 60 cycles that is far longer than any legal start delay and checks that nothing reached the FIFO or the memory port. overrun is read after the offending list has finished.

// File: rtl/txdma_pkg.sv
// Shared constants and types for the descriptor-chained transmit DMA engine.
// Assumes 32-bit words and byte addresses; fragment addresses word aligned.
package txdma_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LEN_W      = 16;
    localparam int LAST_BIT   = 31;
    localparam int MIN_FREE   = 16;
    localparam int BURST_UNIT = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_NEXT,
        S_RD_CTRL,
        S_RD_ADDR,
        S_RD_LEN,
        S_WAIT,
        S_DATA,
        S_END
    } dma_state_t;
endpackage

// File: rtl/txdma_start_rule.sv
// Start rule for one fragment transfer. Purely combinational.
// Assumes: free space and length in bytes; threshold in units of BURST_UNIT bytes.
module txdma_start_rule
    import txdma_pkg::*;
#(
    parameter int FREE_W = 12,
    parameter int THR_W  = 8
) (
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [LEN_W-1:0]  frag_len,
    input  logic [THR_W-1:0]  thresh,
    input  logic              halt,
    output logic              go
);
    localparam int CMP_W = 32;

    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] len_x;
    logic [CMP_W-1:0] burst_x;

    // Widen operands and evaluate both space conditions plus the halt gate.
    always_comb begin
        free_x  = CMP_W'(free_bytes);
        len_x   = CMP_W'(frag_len);
        burst_x = CMP_W'(thresh) * CMP_W'(BURST_UNIT);
        go = !halt && (free_x >= CMP_W'(MIN_FREE))
                   && ((len_x <= free_x) || (free_x >= burst_x));
    end
endmodule

// File: rtl/txdma_tx_gate.sv
// Transmit-enable state toward the MAC, with deferred disable.
// Assumes mac_frame_active stays high for the whole frame on the wire.
module txdma_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_set,
    input  logic disable_set,
    input  logic frame_active,
    output logic tx_en
);
    logic pend_off;

    // Enable wins and clears a pending disable; a disable waits for frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            pend_off <= 1'b0;
        end else if (enable_set) begin
            tx_en    <= 1'b1;
            pend_off <= 1'b0;
        end else if (disable_set || pend_off) begin
            if (frame_active) begin
                pend_off <= 1'b1;
            end else begin
                tx_en    <= 1'b0;
                pend_off <= 1'b0;
            end
        end
    end

    p_enable_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable_set |=> tx_en);

    p_hold_during_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && frame_active) |=> tx_en);
endmodule

// File: rtl/txdma_chain.sv
// Descriptor-chained transmit DMA engine: walks a descriptor list in host
// memory, loads each fragment's address and length, and copies the fragment
// into the transmit FIFO word by word. Also gates MAC transmit enable.
// Assumes one memory read outstanding at a time; response arrives on a later cycle.
module txdma_chain
    import txdma_pkg::*;
#(
    parameter int FREE_W = 12,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              list_ptr_wr,
    input  logic [31:0]       list_ptr_data,
    input  logic [THR_W-1:0]  burst_thresh,
    input  logic              halt,
    input  logic              tx_enable_set,
    input  logic              tx_disable_set,
    input  logic              mac_frame_active,
    output logic              mac_tx_en,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [31:0]       fifo_wdata,
    output logic [2:0]        fifo_wbytes,
    output logic              overrun,
    output logic              list_done
);
    dma_state_t       state;
    logic             waiting;
    logic [31:0]      desc_ptr;
    logic [31:0]      next_ptr;
    logic [31:0]      frag_ptr;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] rem;
    logic             last_frag;
    logic             is_fetch;
    logic [31:0]      fetch_addr;
    logic [2:0]       chunk;
    logic             start_ok;

    txdma_start_rule #(.FREE_W(FREE_W), .THR_W(THR_W)) u_rule (
        .free_bytes (fifo_free),
        .frag_len   (rem),
        .thresh     (burst_thresh),
        .halt       (halt),
        .go         (start_ok)
    );

    txdma_tx_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_set   (tx_enable_set),
        .disable_set  (tx_disable_set),
        .frame_active (mac_frame_active),
        .tx_en        (mac_tx_en)
    );

    // Select the word address each read state fetches.
    always_comb begin
        is_fetch   = 1'b1;
        fetch_addr = desc_ptr;
        unique case (state)
            S_RD_NEXT: fetch_addr = desc_ptr;
            S_RD_CTRL: fetch_addr = desc_ptr + 32'd4;
            S_RD_ADDR: fetch_addr = frag_ptr;
            S_RD_LEN:  fetch_addr = frag_ptr + 32'd4;
            S_DATA:    fetch_addr = cur_addr;
            default:   is_fetch   = 1'b0;
        endcase
    end

    // Bytes carried by the current data word: a full word or the remainder.
    always_comb begin
        chunk = (rem >= LEN_W'(WORD_BYTES)) ? 3'(WORD_BYTES) : rem[2:0];
    end

    // Walker state machine, read issue and FIFO write generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            waiting     <= 1'b0;
            desc_ptr    <= '0;
            next_ptr    <= '0;
            frag_ptr    <= '0;
            cur_addr    <= '0;
            rem         <= '0;
            last_frag   <= 1'b0;
            mem_req     <= 1'b0;
            mem_addr    <= '0;
            fifo_wr     <= 1'b0;
            fifo_wdata  <= '0;
            fifo_wbytes <= '0;
            overrun     <= 1'b0;
            list_done   <= 1'b0;
        end else begin
            mem_req   <= 1'b0;
            fifo_wr   <= 1'b0;
            list_done <= 1'b0;
            if (fifo_wr && fifo_full) begin
                overrun <= 1'b1;
            end
            if (is_fetch && !waiting) begin
                mem_req  <= 1'b1;
                mem_addr <= fetch_addr;
                waiting  <= 1'b1;
            end else if (is_fetch && mem_rvalid) begin
                waiting <= 1'b0;
                unique case (state)
                    S_RD_NEXT: begin
                        next_ptr <= mem_rdata;
                        state    <= S_RD_CTRL;
                    end
                    S_RD_CTRL: begin
                        frag_ptr <= desc_ptr + 32'd8;
                        state    <= S_RD_ADDR;
                    end
                    S_RD_ADDR: begin
                        cur_addr <= {mem_rdata[31:2], 2'b00};
                        state    <= S_RD_LEN;
                    end
                    S_RD_LEN: begin
                        rem       <= mem_rdata[LEN_W-1:0];
                        last_frag <= mem_rdata[LAST_BIT];
                        frag_ptr  <= frag_ptr + 32'd8;
                        if (mem_rdata[LEN_W-1:0] == '0) begin
                            state <= mem_rdata[LAST_BIT] ? S_END : S_RD_ADDR;
                        end else begin
                            state <= S_WAIT;
                        end
                    end
                    default: begin
                        fifo_wr     <= 1'b1;
                        fifo_wdata  <= mem_rdata;
                        fifo_wbytes <= chunk;
                        rem         <= rem - LEN_W'(chunk);
                        cur_addr    <= cur_addr + 32'(WORD_BYTES);
                        if (rem <= LEN_W'(WORD_BYTES)) begin
                            state <= last_frag ? S_END : S_RD_ADDR;
                        end
                    end
                endcase
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (list_ptr_wr && (list_ptr_data != '0)) begin
                            desc_ptr <= list_ptr_data;
                            state    <= S_RD_NEXT;
                        end
                    end
                    S_WAIT: begin
                        if (start_ok) begin
                            state <= S_DATA;
                        end
                    end
                    S_END: begin
                        if (next_ptr == '0) begin
                            list_done <= 1'b1;
                            state     <= S_IDLE;
                        end else begin
                            desc_ptr <= next_ptr;
                            state    <= S_RD_NEXT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_low_space_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && fifo_free < FREE_W'(MIN_FREE)) |=> (state == S_WAIT));

    p_halt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && halt) |=> (state == S_WAIT));

    p_wbytes_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_wbytes >= 3'd1 && fifo_wbytes <= 3'd4));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |=> !list_done);
endmodule

// File: tb/tb_txdma_chain.sv
module tb_txdma_chain;
    localparam int FREE_W = 12;
    localparam int THR_W  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              list_ptr_wr = 1'b0;
    logic [31:0]       list_ptr_data = '0;
    logic [THR_W-1:0]  burst_thresh = '0;
    logic              halt = 1'b0;
    logic              tx_enable_set = 1'b0;
    logic              tx_disable_set = 1'b0;
    logic              mac_frame_active = 1'b0;
    logic              mac_tx_en;
    logic              mem_req;
    logic [31:0]       mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [FREE_W-1:0] fifo_free;
    logic              fifo_full;
    logic              fifo_wr;
    logic [31:0]       fifo_wdata;
    logic [2:0]        fifo_wbytes;
    logic              overrun;
    logic              list_done;

    txdma_chain #(.FREE_W(FREE_W), .THR_W(THR_W)) dut (
        .clk(clk), .rst_n(rst_n), .list_ptr_wr(list_ptr_wr), .list_ptr_data(list_ptr_data),
        .burst_thresh(burst_thresh), .halt(halt), .tx_enable_set(tx_enable_set),
        .tx_disable_set(tx_disable_set), .mac_frame_active(mac_frame_active),
        .mac_tx_en(mac_tx_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_free(fifo_free),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_wbytes(fifo_wbytes), .overrun(overrun), .list_done(list_done)
    );

    // Host memory model: answers each read two cycles after the request.
    logic [31:0] mem [0:8191];
    logic        rv1 = 1'b0;
    logic [31:0] a1 = '0;
    always @(posedge clk) begin
        rv1        <= mem_req;
        a1         <= mem_addr;
        mem_rvalid <= rv1;
        mem_rdata  <= mem[a1[14:2]];
    end

    // FIFO model: occupancy, optional drain, and a capture of every written byte.
    int       depth = 256;
    int       occ = 0;
    bit       drain = 1'b1;
    bit       flush = 1'b0;
    logic [7:0] cap[$];
    always @(posedge clk) begin
        int n;
        n = occ;
        if (flush) n = 0;
        else if (drain) n = (n >= 4) ? n - 4 : 0;
        if (fifo_wr) begin
            for (int i = 0; i < int'(fifo_wbytes); i++) cap.push_back(fifo_wdata[8*i +: 8]);
            n = n + int'(fifo_wbytes);
            if (n > depth) n = depth;
        end
        occ <= n;
    end
    assign fifo_free = (depth > occ) ? FREE_W'(depth - occ) : '0;
    assign fifo_full = (occ >= depth);

    int done_cnt = 0;
    int req_cnt = 0;
    always @(posedge clk) begin
        if (list_done) done_cnt <= done_cnt + 1;
        if (mem_req)   req_cnt  <= req_cnt + 1;
    end

    int checks = 0;
    int errors = 0;
    logic [7:0] expq[$];
    logic [31:0] dp, datap;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Build a chain in memory; fixed_len >= 0 forces a single one-fragment descriptor.
    task automatic build(input int ndesc, input int fixed_len, output logic [31:0] first, output int reqs);
        dp = 32'h400; datap = 32'h4000; reqs = 0; expq = {};
        first = dp;
        for (int d = 0; d < ndesc; d++) begin
            logic [31:0] base;
            int nfrag;
            nfrag = (fixed_len >= 0) ? 1 : 1 + int'($urandom_range(0, 2));
            base = dp;
            dp = dp + 32'(8 + 8 * nfrag);
            mem[base[14:2]] = (d == ndesc - 1) ? 32'h0 : dp;
            mem[base[14:2] + 13'd1] = $urandom;
            reqs += 2;
            for (int f = 0; f < nfrag; f++) begin
                int len;
                logic [31:0] fa, lw, ent;
                len = (fixed_len >= 0) ? fixed_len : int'($urandom_range(0, 40));
                fa = datap;
                datap = datap + 32'(((len + 3) / 4) * 4 + 4);
                for (int w = 0; w < (len + 3) / 4; w++) mem[fa[14:2] + 13'(w)] = $urandom;
                for (int j = 0; j < len; j++) begin
                    logic [31:0] wd;
                    logic [31:0] ba;
                    ba = fa + 32'(j);
                    wd = mem[ba[14:2]];
                    expq.push_back(wd[8*(j%4) +: 8]);
                end
                lw = 32'(len);
                lw[31] = (f == nfrag - 1);
                ent = base + 32'(8 + 8 * f);
                mem[ent[14:2]] = fa;
                mem[ent[14:2] + 13'd1] = lw;
                reqs += 2 + (len + 3) / 4;
            end
        end
    endtask

    task automatic start_list(input logic [31:0] a);
        @(negedge clk); list_ptr_wr = 1'b1; list_ptr_data = a;
        @(negedge clk); list_ptr_wr = 1'b0; list_ptr_data = '0;
    endtask

    task automatic wait_done(input int base);
        for (int k = 0; k < 3000 && done_cnt == base; k++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic cmp_stream(input int b_cap, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < expq.size(); i++)
            if (b_cap + i >= cap.size() || cap[b_cap + i] !== expq[i]) bad++;
        chk(bad == 0, req, "byte mismatches", bad, 0);
    endtask

    initial begin
        logic [31:0] first;
        int reqs, b_done, b_req, b_cap;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8192; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mac_tx_en == 1'b0, "R9", "tx_en after reset", int'(mac_tx_en), 0);
        chk(overrun == 1'b0 && list_done == 1'b0, "R8", "flags after reset", int'(overrun), 0);

        // R9: enable raises at the next edge.
        tx_enable_set = 1'b1; @(negedge clk); tx_enable_set = 1'b0;
        chk(mac_tx_en == 1'b1, "R9", "tx_en after enable", int'(mac_tx_en), 1);
        // R10: disable deferred while a frame is active.
        mac_frame_active = 1'b1;
        tx_disable_set = 1'b1; @(negedge clk); tx_disable_set = 1'b0;
        repeat (3) @(negedge clk);
        chk(mac_tx_en == 1'b1, "R10", "tx_en held during frame", int'(mac_tx_en), 1);
        mac_frame_active = 1'b0; @(negedge clk);
        chk(mac_tx_en == 1'b0, "R10", "tx_en after frame end", int'(mac_tx_en), 0);
        // R10: enable cancels a pending disable.
        tx_enable_set = 1'b1; @(negedge clk); tx_enable_set = 1'b0;
        mac_frame_active = 1'b1;
        tx_disable_set = 1'b1; @(negedge clk); tx_disable_set = 1'b0;
        tx_enable_set = 1'b1; @(negedge clk); tx_enable_set = 1'b0;
        mac_frame_active = 1'b0; repeat (2) @(negedge clk);
        chk(mac_tx_en == 1'b1, "R10", "enable cancels pending disable", int'(mac_tx_en), 1);
        // R10: disable with no frame drops at the next edge.
        tx_disable_set = 1'b1; @(negedge clk); tx_disable_set = 1'b0;
        chk(mac_tx_en == 1'b0, "R10", "idle disable", int'(mac_tx_en), 0);

        // R1: a zero pointer write is ignored.
        b_req = req_cnt;
        start_list(32'h0);
        repeat (60) @(negedge clk);
        chk(req_cnt == b_req, "R1", "reads after zero pointer", req_cnt - b_req, 0);

        // Random chains with transmission disabled (R9: data still moves).
        for (int it = 0; it < 20; it++) begin
            burst_thresh = THR_W'($urandom_range(0, 3));
            build(1 + int'($urandom_range(0, 3)), -1, first, reqs);
            b_done = done_cnt; b_req = req_cnt; b_cap = cap.size();
            start_list(first);
            if (it == 0) begin
                repeat (3) @(negedge clk);
                start_list(32'h800); // R1: write while busy is ignored
            end
            wait_done(b_done);
            chk(done_cnt - b_done == 1, "R7", "done pulses per list", done_cnt - b_done, 1);
            chk(cap.size() - b_cap == expq.size(), "R6", "bytes written", cap.size() - b_cap, expq.size());
            cmp_stream(b_cap, "R2");
            chk(req_cnt - b_req == reqs, "R11", "read count", req_cnt - b_req, reqs);
        end
        chk(overrun == 1'b0, "R8", "no overrun with room", int'(overrun), 0);

        // R5: zero-length sole fragment.
        build(1, 0, first, reqs);
        b_done = done_cnt; b_req = req_cnt; b_cap = cap.size();
        start_list(first); wait_done(b_done);
        chk(cap.size() == b_cap, "R5", "bytes for zero fragment", cap.size() - b_cap, 0);
        chk(req_cnt - b_req == 4, "R5", "reads for zero fragment", req_cnt - b_req, 4);
        chk(done_cnt - b_done == 1, "R7", "done after zero fragment", done_cnt - b_done, 1);

        // R4: halt holds the fragment start.
        drain = 1'b0; do_flush();
        halt = 1'b1; burst_thresh = '0;
        build(1, 8, first, reqs);
        b_done = done_cnt; b_cap = cap.size();
        start_list(first);
        repeat (60) @(negedge clk);
        chk(cap.size() == b_cap, "R4", "bytes while halted", cap.size() - b_cap, 0);
        halt = 1'b0; wait_done(b_done);
        chk(cap.size() - b_cap == 8, "R4", "bytes after release", cap.size() - b_cap, 8);

        // R3: fewer than 16 bytes free blocks the start.
        do_flush(); depth = 12;
        build(1, 8, first, reqs);
        b_done = done_cnt; b_cap = cap.size();
        start_list(first);
        repeat (60) @(negedge clk);
        chk(cap.size() == b_cap, "R3", "bytes with 12 free", cap.size() - b_cap, 0);
        depth = 20; wait_done(b_done);
        chk(cap.size() - b_cap == 8, "R3", "bytes once 20 free", cap.size() - b_cap, 8);
        cmp_stream(b_cap, "R3");

        // R3: fragment longer than free space and below the burst threshold.
        do_flush(); depth = 20; burst_thresh = THR_W'(1);
        build(1, 30, first, reqs);
        b_done = done_cnt; b_cap = cap.size();
        start_list(first);
        repeat (60) @(negedge clk);
        chk(cap.size() == b_cap, "R3", "bytes below threshold", cap.size() - b_cap, 0);
        chk(overrun == 1'b0, "R8", "overrun before start", int'(overrun), 0);
        burst_thresh = '0; wait_done(b_done);
        chk(cap.size() - b_cap == 30, "R6", "bytes of 30-byte fragment", cap.size() - b_cap, 30);
        chk(overrun == 1'b1, "R8", "overrun after overfill", int'(overrun), 1);

        // R8: flag stays set across a later clean list.
        do_flush(); depth = 256; drain = 1'b1;
        build(1, 5, first, reqs);
        b_done = done_cnt;
        start_list(first); wait_done(b_done);
        chk(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule